// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits beside a PCIe root port and turns inbound message-signalled interrupt writes into a single level interrupt for the host. Software programs a 64-bit target address. Every inbound memory write is compared against it. When a full 32-bit write hits that address exactly, the write data is taken as a vector number. The vector sets a pending bit in one of several 32-vector groups.

Each group has three registers on a small 32-bit register bus: an enable word, a mask word and a status word. Status bits are cleared by writing ones to them. A disabled vector is dropped. A masked vector is still recorded, but it raises no interrupt until it is unmasked. The host interrupt line is the registered OR of every status bit that is both enabled and unmasked.

Top module: `msi_capture_ctrl`

## Requirements
- R1: The target address low word sits at register offset 0x820 and the high word at 0x824. Both are written in full and read back unchanged.
- R2: A capture needs all of the following: `in_valid` high, `in_be` equal to 4'b1111, and `in_addr` equal to {high word, low word}. Any other inbound write changes no status bit.
- R3: A captured value v below 256 whose enable bit is set sets status bit v%32 of group v/32. Group g has its enable register at 0x828+12g, its mask register at 0x82C+12g and its status register at 0x830+12g.
- R4: A captured vector whose enable bit is clear leaves its status bit unchanged.
- R5: A captured data value of 256 or more changes no status bit.
- R6: Writing a word to a status register clears each status bit that has a 1 in the written word. Bits written as 0 keep their value. A register write never sets a status bit.
- R7: When a capture and a status clear hit the same bit in the same cycle, the bit ends set.
- R8: A vector that is enabled but masked still sets its status bit. It drives `irq_o` only once its mask bit is cleared.
- R9: `irq_o` equals the OR over all groups of status AND enable AND NOT mask, registered. It changes one clock edge after the edge that updates status.
- R10: After reset, all registers and `irq_o` are zero. `reg_rdata` is loaded on the edge where `reg_ren` is high. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Inbound memory write present |
| in_addr | input | 64 | Inbound write address |
| in_be | input | 4 | Inbound write byte enables |
| in_data | input | 32 | Inbound write data (vector number) |
| irq_o | output | 1 | Host interrupt, level |

## Verification
The hardest case to reach from the ports is a capture and a software clear that land on the same status bit in the same clock. The bench drives the register bus and the inbound write path on the same falling edge to line them up. It also fires targeted vectors into groups with mixed enable and mask words, then flips the mask afterwards. This shows that status recorded under mask later reaches `irq_o`. Seeded random traffic adds near-miss addresses, partial byte enables and out-of-range vector values on top of these directed cases.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned REG_ADDR_W  = 12;
  localparam int unsigned WORD_W      = 32;
  localparam logic [REG_ADDR_W-1:0] OFS_TGT_LO = 12'h820;
  localparam logic [REG_ADDR_W-1:0] OFS_TGT_HI = 12'h824;
  localparam logic [REG_ADDR_W-1:0] OFS_GRP0   = 12'h828;
  localparam int unsigned GRP_STRIDE  = 12;

  typedef enum logic [1:0] {
    GREG_ENABLE = 2'd0,
    GREG_MASK   = 2'd1,
    GREG_STATUS = 2'd2
  } grp_reg_e;

  function automatic logic [REG_ADDR_W-1:0] grp_ofs(int unsigned g, grp_reg_e kind);
    return OFS_GRP0 + REG_ADDR_W'(g * GRP_STRIDE) + REG_ADDR_W'(4 * int'(kind));
  endfunction
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8
) (
  input  logic [REG_ADDR_W-1:0] addr,
  output logic                  sel_lo,
  output logic                  sel_hi,
  output logic [NUM_GROUPS-1:0] sel_en,
  output logic [NUM_GROUPS-1:0] sel_mask,
  output logic [NUM_GROUPS-1:0] sel_stat
);
  assign sel_lo = (addr == OFS_TGT_LO);
  assign sel_hi = (addr == OFS_TGT_HI);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign sel_en[g]   = (addr == grp_ofs(g, GREG_ENABLE));
    assign sel_mask[g] = (addr == grp_ofs(g, GREG_MASK));
    assign sel_stat[g] = (addr == grp_ofs(g, GREG_STATUS));
  end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group #(
  parameter int unsigned W = 32,
  localparam int unsigned BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_valid,
  input  logic [BW-1:0] cap_bit,
  input  logic          en_we,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  enable,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  status,
  output logic          pend
);
  logic [W-1:0] set_vec, clr_vec, status_nxt;

  always_comb begin
    set_vec = '0;
    if (cap_valid && enable[cap_bit]) set_vec[cap_bit] = 1'b1;
    clr_vec    = clr_we ? wdata : '0;
    status_nxt = (status & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      if (en_we)   enable <= wdata;
      if (mask_we) mask   <= wdata;
      status <= status_nxt;
    end
  end

  assign pend = |(status & enable & ~mask);

  // R3 and R7: an enabled capture always leaves its bit set, even against a clear
  p_cap_sets_r3: assert property (@(posedge clk) disable iff (rst)
    cap_valid && enable[cap_bit] |=> status[$past(cap_bit)]);

  // R4: a disabled vector that was not pending stays clear
  p_disabled_drop_r4: assert property (@(posedge clk) disable iff (rst)
    cap_valid && !enable[cap_bit] && !status[cap_bit] |=> !status[$past(cap_bit)]);

  // R6: a clear with no capture leaves none of the written ones set
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    clr_we && !cap_valid |=> (status & $past(wdata)) == '0);

  // R6: without a capture no status bit rises
  p_no_spurious_set_r6: assert property (@(posedge clk) disable iff (rst)
    !cap_valid |=> (status & ~$past(status)) == '0);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  localparam int unsigned TOTAL_VEC = NUM_GROUPS * WORD_W,
  localparam int unsigned BIT_W     = $clog2(WORD_W),
  localparam int unsigned GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wen,
  input  logic                  reg_ren,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  input  logic                  in_valid,
  input  logic [63:0]           in_addr,
  input  logic [3:0]            in_be,
  input  logic [WORD_W-1:0]     in_data,
  output logic                  irq_o
);
  logic [WORD_W-1:0] tgt_lo, tgt_hi;
  logic sel_lo, sel_hi;
  logic [NUM_GROUPS-1:0] sel_en, sel_mask, sel_stat, pend_vec;
  logic [WORD_W-1:0] en_w [NUM_GROUPS];
  logic [WORD_W-1:0] mask_w [NUM_GROUPS];
  logic [WORD_W-1:0] stat_w [NUM_GROUPS];
  logic [NUM_GROUPS*WORD_W-1:0] status_flat;
  logic cap_hit;
  logic [GRP_W-1:0] cap_grp;
  logic [BIT_W-1:0] cap_bit;
  logic [WORD_W-1:0] rd_val;

  msi_reg_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
    .addr(reg_addr), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .sel_en(sel_en), .sel_mask(sel_mask), .sel_stat(sel_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else if (reg_wen) begin
      if (sel_lo) tgt_lo <= reg_wdata;
      if (sel_hi) tgt_hi <= reg_wdata;
    end
  end

  assign cap_hit = in_valid && (in_be == 4'b1111) && (in_addr == {tgt_hi, tgt_lo})
                   && (in_data < WORD_W'(TOTAL_VEC));
  assign cap_bit = in_data[BIT_W-1:0];
  if (NUM_GROUPS > 1) begin : g_multi
    assign cap_grp = in_data[BIT_W +: GRP_W];
  end else begin : g_single
    assign cap_grp = '0;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    msi_vec_group #(.W(WORD_W)) u_grp (
      .clk(clk), .rst(rst),
      .cap_valid(cap_hit && (cap_grp == GRP_W'(g))),
      .cap_bit(cap_bit),
      .en_we(reg_wen && sel_en[g]),
      .mask_we(reg_wen && sel_mask[g]),
      .clr_we(reg_wen && sel_stat[g]),
      .wdata(reg_wdata),
      .enable(en_w[g]), .mask(mask_w[g]), .status(stat_w[g]),
      .pend(pend_vec[g])
    );
    assign status_flat[g*WORD_W +: WORD_W] = stat_w[g];
  end

  always_comb begin
    rd_val = '0;
    if (sel_lo) rd_val = tgt_lo;
    if (sel_hi) rd_val = tgt_hi;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel_en[g])   rd_val = en_w[g];
      if (sel_mask[g]) rd_val = mask_w[g];
      if (sel_stat[g]) rd_val = stat_w[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_ren) reg_rdata <= rd_val;
      irq_o <= |pend_vec;
    end
  end

  // R2: an inbound write that misses the target and no register write leave status alone
  p_miss_no_change_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !cap_hit && !reg_wen |=> $stable(status_flat));

  // R9: the host line stays low while no group was pending on the previous edge
  p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
    pend_vec == '0 |=> !irq_o);
endmodule

// File: tb/msi_capture_ctrl_tb.sv
module msi_capture_ctrl_tb;
  localparam int NG = 8;
  logic clk = 0, rst = 1;
  logic reg_wen = 0, reg_ren = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic in_valid = 0;
  logic [63:0] in_addr = 0;
  logic [3:0] in_be = 0;
  logic [31:0] in_data = 0, rv;
  logic irq_o;

  int total = 0, bad = 0;
  logic [31:0] m_en [NG], m_mk [NG], m_st [NG];
  logic [63:0] m_tgt;

  always #2.5 clk = ~clk;

  msi_capture_ctrl u_dut (.clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_addr(in_addr), .in_be(in_be), .in_data(in_data), .irq_o(irq_o));

  function automatic logic [11:0] ofs(int g, int k); return 12'h828 + 12'(12*g + 4*k); endfunction
  function automatic logic m_irq();
    logic r = 0;
    for (int g = 0; g < NG; g++) r |= |(m_st[g] & m_en[g] & ~m_mk[g]);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    if (a == 12'h820) m_tgt[31:0] = d;
    if (a == 12'h824) m_tgt[63:32] = d;
    for (int g = 0; g < NG; g++) begin
      if (a == ofs(g,0)) m_en[g] = d;
      if (a == ofs(g,1)) m_mk[g] = d;
      if (a == ofs(g,2)) m_st[g] &= ~d;
    end
  endtask

  task automatic model_msi(logic [63:0] a, logic [3:0] be, logic [31:0] d);
    if (a == m_tgt && be == 4'hf && d < 256 && m_en[d/32][d%32]) m_st[d/32][d%32] = 1'b1;
  endtask

  // drive both paths in one cycle; pass en=0 to skip one
  task automatic cycle(bit w, logic [11:0] a, logic [31:0] d,
                       bit m, logic [63:0] ia, logic [3:0] be, logic [31:0] id);
    reg_wen = w; reg_addr = a; reg_wdata = d;
    in_valid = m; in_addr = ia; in_be = be; in_data = id;
    @(negedge clk);
    reg_wen = 0; in_valid = 0;
    if (w) model_wr(a, d);
    if (m) model_msi(ia, be, id);
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d); cycle(1, a, d, 0, 0, 0, 0); endtask
  task automatic msi(logic [63:0] ia, logic [3:0] be, logic [31:0] id); cycle(0, 0, 0, 1, ia, be, id); endtask
  task automatic rd(logic [11:0] a, output logic [31:0] v);
    reg_ren = 1; reg_addr = a; @(negedge clk); reg_ren = 0; v = reg_rdata;
  endtask
  task automatic idle(); @(negedge clk); endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] T;
    for (int g = 0; g < NG; g++) begin m_en[g] = 0; m_mk[g] = 0; m_st[g] = 0; end
    m_tgt = 0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 irq reset", 32'(irq_o), 0);
    rd(12'h820, rv); check("R10 tgt reset", rv, 0);
    rd(ofs(7,2), rv); check("R10 status reset", rv, 0);
    // R1 target address
    T = 64'h0000_00ab_fee0_1000;
    wr(12'h820, T[31:0]); wr(12'h824, T[63:32]);
    rd(12'h820, rv); check("R1 lo", rv, T[31:0]);
    rd(12'h824, rv); check("R1 hi", rv, T[63:32]);
    rd(12'h7fc, rv); check("R10 unmapped", rv, 0);
    // R3 capture into group 6 (vector 200 -> bit 8, status at 0x878)
    wr(ofs(6,0), 32'h0000_0100);
    msi(T, 4'hf, 200);
    check("R9 irq not yet", 32'(irq_o), 0);
    idle(); check("R9 irq one edge later", 32'(irq_o), 1);
    rd(12'h878, rv); check("R3 group6 status", rv, 32'h100);
    // R6 write-one-to-clear
    wr(ofs(6,2), 32'h0000_0000); rd(ofs(6,2), rv); check("R6 zero write keeps", rv, 32'h100);
    wr(ofs(6,2), 32'hffff_ffff); rd(ofs(6,2), rv); check("R6 clear", rv, 0);
    idle(); check("R9 irq drop", 32'(irq_o), 0);
    // R4 disabled vector
    msi(T, 4'hf, 201); rd(ofs(6,2), rv); check("R4 disabled", rv, 0);
    // R2 misses
    wr(ofs(0,0), 32'hffff_ffff);
    msi(T ^ 64'h1_0000_0000, 4'hf, 3); msi(T, 4'h7, 3); msi(T + 4, 4'hf, 3);
    rd(ofs(0,2), rv); check("R2 misses", rv, 0);
    // R5 out of range
    msi(T, 4'hf, 256); msi(T, 4'hf, 32'h8000_0003);
    rd(ofs(0,2), rv); check("R5 out of range", rv, 0);
    // R8 masked
    wr(ofs(0,1), 32'h0000_0010);
    msi(T, 4'hf, 4); idle();
    check("R8 masked no irq", 32'(irq_o), 0);
    rd(ofs(0,2), rv); check("R8 masked status", rv, 32'h10);
    wr(ofs(0,1), 0); idle(); check("R8 unmask irq", 32'(irq_o), 1);
    // R7 capture vs clear same bit same cycle
    cycle(1, ofs(0,2), 32'h0000_0010, 1, T, 4'hf, 4);
    rd(ofs(0,2), rv); check("R7 capture wins", rv, 32'h10);
    cycle(1, ofs(0,2), 32'h0000_0010, 1, T, 4'hf, 5);
    rd(ofs(0,2), rv); check("R7 other bit cleared", rv, 32'h20);
    // random mix (R3 R4 R6 R8 R9)
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int g = $urandom_range(0, NG-1);
      if (op < 2) wr(ofs(g, 0), $urandom());
      else if (op < 3) wr(ofs(g, 1), $urandom() & $urandom());
      else if (op < 4) wr(ofs(g, 2), $urandom() & $urandom());
      else if (op < 5) cycle(1, ofs(g, 2), $urandom(), 1, T, 4'hf, 32'($urandom_range(0, 299)));
      else msi(($urandom_range(0, 7) == 0) ? T ^ (64'h1 << $urandom_range(0, 63)) : T,
               ($urandom_range(0, 7) == 0) ? 4'h3 : 4'hf, 32'($urandom_range(0, 299)));
      idle();
      check("R9 random irq", 32'(irq_o), 32'(m_irq()));
      if (i % 50 == 0)
        for (int k = 0; k < NG; k++) begin rd(ofs(k, 2), rv); check("R3 random status", rv, m_st[k]); end
    end
    for (int k = 0; k < NG; k++) begin rd(ofs(k, 0), rv); check("R3 enable readback", rv, m_en[k]); end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule